// File: doc/BRIEF.md
# Serial Port Register Interface

This block is the software-facing control and status front end of a simple serial port. A word-wide register bus reaches storage for line settings, general control, FIFO control, modem control and the baud divisor. The same bus reads hard-wired status words, reads a single receive holding byte and writes transmit data. The serializer, the deserializer and the baud generator sit outside. This block hands transmit bytes out as a one-cycle strobe and takes received bytes in over a valid/ready handshake.

The receive side holds at most one byte. A received byte is taken only while nothing is held. Reading the receive data offset empties the holder. A loopback control bit sends transmit writes into the holder instead of out of the port. The receive and transmit interrupts each have a mode bit in the general control register. In level mode the interrupt is a sticky output. In pulse mode a separate output is high for a single cycle.

Top module: `sport_regif`

## Requirements
- R1: After reset every stored register reads 0, all interrupt outputs and `tx_valid` are low, `rx_ready` is high, and the status word at offset 0x10 reads 0x6.
- R2: The line settings (0x00) and baud divisor (0x28) registers store all 32 written bits and read back unchanged.
- R3: A write to FIFO control (0x08) stores the value with bits 1 and 2 cleared. A read of it shows bit 3 as 0. A read of modem control (0x0C) shows only bits 0 and 4 of the stored value (mask 0x11).
- R4: Offset 0x10 reads 0x6 ORed with the receive-available flag in bit 0. Offset 0x18 reads the receive-available flag alone. Offsets 0x14 and 0x1C read 0. Writes to 0x10, 0x14, 0x18, 0x1C and 0x24 change no stored state and no output.
- R5: With general control bit 5 clear, a write to 0x20 raises `tx_valid` for exactly one cycle after the write edge, with `tx_data` equal to bits 7:0 of the written value.
- R6: With general control bit 5 set, a write to 0x20 loads bits 7:0 into the receive holder, sets receive-available and raises the receive interrupt. `tx_valid` stays low.
- R7: `rx_ready` is high only when no byte is held and no loopback write is on the bus in that cycle. A byte presented with `rx_valid` while `rx_ready` is high is stored and sets receive-available.
- R8: A receive event (serial accept or loopback) with general control bit 8 set drives `irq_rx_level` high until it is cleared. With bit 8 clear it drives `irq_rx_pulse` high for exactly one cycle and leaves the level output low.
- R9: Every write to 0x20 is a transmit event. With general control bit 9 set it drives `irq_tx_level` high. With bit 9 clear it drives `irq_tx_pulse` high for exactly one cycle.
- R10: A write to general control (0x04) sets `irq_tx_level` to the written bit 9. If the written bit 8 is 0, it forces `irq_rx_level` low.
- R11: A read of 0x24 returns the held byte in bits 7:0, clears receive-available, and drops `irq_rx_level` when general control bit 8 is set.
- R12: When a loopback write and a presented serial byte fall in the same cycle, the loopback byte is stored and the serial byte is refused. It is then accepted once the holder has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Serial input byte offered |
| rx_ready | output | 1 | Serial input byte can be taken |
| rx_data | input | 8 | Serial input byte |
| irq_rx_pulse | output | 1 | Receive interrupt, pulse mode |
| irq_rx_level | output | 1 | Receive interrupt, level mode |
| irq_tx_pulse | output | 1 | Transmit interrupt, pulse mode |
| irq_tx_level | output | 1 | Transmit interrupt, level mode |

## Verification
A loopback write and an offered serial byte both want to load the single receive holder in the same cycle. The bench provokes this by presenting `rx_valid` on the same clock as a write to the transmit offset while loopback is enabled. It judges the outcome in three steps. It checks that `rx_ready` is low in that cycle. It checks that the first read of the receive offset returns the loopback byte. It keeps the serial byte offered, so a second read must return that byte after the holder frees up.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 6;

  localparam logic [OFF_W-1:0] OFF_LINE  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_FIFO  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MODEM = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_ERR   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_FSTAT = 6'h18;
  localparam logic [OFF_W-1:0] OFF_MSTAT = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_TXD   = 6'h20;
  localparam logic [OFF_W-1:0] OFF_RXD   = 6'h24;
  localparam logic [OFF_W-1:0] OFF_BAUD  = 6'h28;

  // general control bit positions that other logic decodes
  localparam int LOOP_BIT  = 5;
  localparam int RXLVL_BIT = 8;
  localparam int TXLVL_BIT = 9;

  // FIFO control: self-clearing reset bits are dropped when stored
  function automatic logic [REG_W-1:0] fifo_store(input logic [REG_W-1:0] v);
    return v & ~REG_W'(32'h0000_0006);
  endfunction

  // FIFO control: reserved bit 3 always reads zero
  function automatic logic [REG_W-1:0] fifo_view(input logic [REG_W-1:0] v);
    return v & ~REG_W'(32'h0000_0008);
  endfunction

  // modem control: only bits 0 and 4 are visible
  function automatic logic [REG_W-1:0] modem_view(input logic [REG_W-1:0] v);
    return v & REG_W'(32'h0000_0011);
  endfunction

  // transmit side always empty (bits 2:1), bit 0 is receive-available
  function automatic logic [REG_W-1:0] stat_word(input logic avail);
    return REG_W'(32'h0000_0006) | REG_W'(avail);
  endfunction
endpackage

// File: rtl/sport_ctl_regs.sv
module sport_ctl_regs
  import sport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] line_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] fifo_q,
  output logic [REG_W-1:0] modem_q,
  output logic [REG_W-1:0] baud_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      ctrl_q  <= '0;
      fifo_q  <= '0;
      modem_q <= '0;
      baud_q  <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_LINE:  line_q  <= wr_data;
        OFF_CTRL:  ctrl_q  <= wr_data;
        OFF_FIFO:  fifo_q  <= fifo_store(wr_data);
        OFF_MODEM: modem_q <= wr_data;
        OFF_BAUD:  baud_q  <= wr_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/sport_rx_hold.sv
module sport_rx_hold
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_load,
  input  logic [BYTE_W-1:0] loop_byte,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              rd_take,
  output logic              in_ready,
  output logic              in_take,
  output logic [BYTE_W-1:0] hold_q,
  output logic              avail_q
);
  // a loopback write owns the holder in its cycle
  assign in_ready = !avail_q && !loop_load;
  assign in_take  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      avail_q <= 1'b0;
    end else if (loop_load) begin
      hold_q  <= loop_byte;
      avail_q <= 1'b1;
    end else if (in_take) begin
      hold_q  <= in_byte;
      avail_q <= 1'b1;
    end else if (rd_take) begin
      avail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_irq_gen.sv
module sport_irq_gen
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              new_rx_lvl,
  input  logic              new_tx_lvl,
  input  logic              rx_lvl_mode,
  input  logic              tx_lvl_mode,
  input  logic              rx_event,
  input  logic              tx_event,
  input  logic              rx_read,
  input  logic              tx_out,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              irq_rx_pulse,
  output logic              irq_rx_level,
  output logic              irq_tx_pulse,
  output logic              irq_tx_level,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx_pulse <= 1'b0;
      irq_tx_pulse <= 1'b0;
      irq_rx_level <= 1'b0;
      irq_tx_level <= 1'b0;
      tx_valid     <= 1'b0;
      tx_data      <= '0;
    end else begin
      irq_rx_pulse <= rx_event && !rx_lvl_mode;
      irq_tx_pulse <= tx_event && !tx_lvl_mode;
      tx_valid     <= tx_out;
      if (tx_out) tx_data <= tx_byte;

      // receive level: set by event, cleared by read, forced low by control write
      if (ctrl_wr && !new_rx_lvl)           irq_rx_level <= 1'b0;
      else if (rx_event && rx_lvl_mode)     irq_rx_level <= 1'b1;
      else if (rx_read && rx_lvl_mode)      irq_rx_level <= 1'b0;

      // transmit level follows control writes, set by transmit event
      if (ctrl_wr)                          irq_tx_level <= new_tx_lvl;
      else if (tx_event && tx_lvl_mode)     irq_tx_level <= 1'b1;
    end
  end
endmodule

// File: rtl/sport_regif.sv
module sport_regif
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq_rx_pulse,
  output logic              irq_rx_level,
  output logic              irq_tx_pulse,
  output logic              irq_tx_level
);
  logic [REG_W-1:0]  line_q, ctrl_q, fifo_q, modem_q, baud_q;
  logic [BYTE_W-1:0] hold_q;
  logic              rx_avail;

  // named internal events
  logic acc_wr, acc_rd, wr_ctrl, wr_txd, rd_rxd;
  logic loop_on, loop_load, tx_out, in_take, rx_event;

  assign acc_wr    = bus_sel && bus_wr;
  assign acc_rd    = bus_sel && !bus_wr;
  assign wr_ctrl   = acc_wr && (bus_addr == OFF_CTRL);
  assign wr_txd    = acc_wr && (bus_addr == OFF_TXD);
  assign rd_rxd    = acc_rd && (bus_addr == OFF_RXD);
  assign loop_on   = ctrl_q[LOOP_BIT];
  assign loop_load = wr_txd && loop_on;
  assign tx_out    = wr_txd && !loop_on;
  assign rx_event  = loop_load || in_take;

  sport_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr),
    .wr_off  (bus_addr),
    .wr_data (bus_wdata),
    .line_q  (line_q),
    .ctrl_q  (ctrl_q),
    .fifo_q  (fifo_q),
    .modem_q (modem_q),
    .baud_q  (baud_q)
  );

  sport_rx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_load (loop_load),
    .loop_byte (bus_wdata[BYTE_W-1:0]),
    .in_valid  (rx_valid),
    .in_byte   (rx_data),
    .rd_take   (rd_rxd),
    .in_ready  (rx_ready),
    .in_take   (in_take),
    .hold_q    (hold_q),
    .avail_q   (rx_avail)
  );

  sport_irq_gen u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (wr_ctrl),
    .new_rx_lvl   (bus_wdata[RXLVL_BIT]),
    .new_tx_lvl   (bus_wdata[TXLVL_BIT]),
    .rx_lvl_mode  (ctrl_q[RXLVL_BIT]),
    .tx_lvl_mode  (ctrl_q[TXLVL_BIT]),
    .rx_event     (rx_event),
    .tx_event     (wr_txd),
    .rx_read      (rd_rxd),
    .tx_out       (tx_out),
    .tx_byte      (bus_wdata[BYTE_W-1:0]),
    .irq_rx_pulse (irq_rx_pulse),
    .irq_rx_level (irq_rx_level),
    .irq_tx_pulse (irq_tx_pulse),
    .irq_tx_level (irq_tx_level),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data)
  );

  always_comb begin
    case (bus_addr)
      OFF_LINE:  bus_rdata = line_q;
      OFF_CTRL:  bus_rdata = ctrl_q;
      OFF_FIFO:  bus_rdata = fifo_view(fifo_q);
      OFF_MODEM: bus_rdata = modem_view(modem_q);
      OFF_STAT:  bus_rdata = stat_word(rx_avail);
      OFF_FSTAT: bus_rdata = REG_W'(rx_avail);
      OFF_RXD:   bus_rdata = REG_W'(hold_q);
      OFF_BAUD:  bus_rdata = baud_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sport_checks.sv
module sport_checks
  import sport_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [OFF_W-1:0] bus_addr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [REG_W-1:0] bus_rdata,
  input logic             tx_valid,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             irq_tx_level,
  input logic             rx_avail,
  input logic             loop_load,
  input logic             rd_rxd,
  input logic             in_take
);
  a_r7_ready_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !rx_avail);

  a_r7_accept_sets_avail: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |=> rx_avail);

  a_r5_tx_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_sel && bus_wr && (bus_addr == OFF_TXD)));

  a_r6_loop_no_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    loop_load |=> !tx_valid);

  a_r10_tx_level_follows_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == OFF_CTRL)) |=> (irq_tx_level == $past(bus_wdata[TXLVL_BIT])));

  a_r11_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !in_take) |=> !rx_avail);

  a_r4_status_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == OFF_STAT)) |-> (bus_rdata == {29'd0, 2'b11, rx_avail}));

  a_r12_loop_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_load && rx_valid) |-> !rx_ready);
endmodule

bind sport_regif sport_checks u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .tx_valid     (tx_valid),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .irq_tx_level (irq_tx_level),
  .rx_avail     (rx_avail),
  .loop_load    (loop_load),
  .rd_rxd       (rd_rxd),
  .in_take      (in_take)
);

// File: tb/sport_regif_bench.sv
module sport_regif_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        irq_rx_pulse, irq_rx_level, irq_tx_pulse, irq_tx_level;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sport_regif u_sport_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .irq_rx_pulse(irq_rx_pulse),
    .irq_rx_level(irq_rx_level), .irq_tx_pulse(irq_tx_pulse),
    .irq_tx_level(irq_tx_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 rdy = rx_ready;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 irq outs", {28'd0, irq_rx_pulse, irq_rx_level, irq_tx_pulse, irq_tx_level}, 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    rd(6'h10, v); chk("R1 status", v, 32'h6);
    rd(6'h04, v); chk("R1 ctrl", v, 0);
    rd(6'h28, v); chk("R1 baud", v, 0);
  endtask

  task automatic t_plain_regs();
    logic [31:0] v;
    wr(6'h00, 32'hDEAD_BEEF); rd(6'h00, v); chk("R2 line", v, 32'hDEAD_BEEF);
    wr(6'h28, 32'h1234_5678); rd(6'h28, v); chk("R2 baud", v, 32'h1234_5678);
    wr(6'h08, 32'h0000_00FF); rd(6'h08, v); chk("R3 fifo masks", v, 32'h0000_00F1);
    wr(6'h08, 32'h0000_0006); rd(6'h08, v); chk("R3 fifo self-clear", v, 0);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); chk("R3 modem view", v, 32'h11);
  endtask

  task automatic t_status_ignore();
    logic [31:0] v;
    wr(6'h10, 32'hFF); wr(6'h14, 32'hFF); wr(6'h18, 32'hFF);
    wr(6'h1C, 32'hFF); wr(6'h24, 32'hFF);
    chk("R4 no tx strobe", 32'(tx_valid), 0);
    chk("R4 no rx irq", {30'd0, irq_rx_pulse, irq_rx_level}, 0);
    rd(6'h10, v); chk("R4 status", v, 32'h6);
    rd(6'h14, v); chk("R4 err", v, 0);
    rd(6'h18, v); chk("R4 fstat", v, 0);
    rd(6'h1C, v); chk("R4 mstat", v, 0);
    rd(6'h24, v); chk("R4 rx untouched", v, 0);
  endtask

  task automatic t_tx_pulse();
    wr(6'h04, 32'h0);
    wr(6'h20, 32'h0000_01A5);
    chk("R5 tx_valid", 32'(tx_valid), 1);
    chk("R5 tx_data", 32'(tx_data), 32'hA5);
    chk("R9 tx pulse", 32'(irq_tx_pulse), 1);
    chk("R9 tx level low", 32'(irq_tx_level), 0);
    @(posedge clk); #1;
    chk("R5 tx_valid one cycle", 32'(tx_valid), 0);
    chk("R9 tx pulse one cycle", 32'(irq_tx_pulse), 0);
  endtask

  task automatic t_tx_level();
    wr(6'h04, 32'h200);
    chk("R10 tx level on ctrl", 32'(irq_tx_level), 1);
    wr(6'h20, 32'h3C);
    chk("R9 tx level held", 32'(irq_tx_level), 1);
    chk("R9 no pulse in level", 32'(irq_tx_pulse), 0);
    wr(6'h04, 32'h0);
    chk("R10 tx level off", 32'(irq_tx_level), 0);
  endtask

  task automatic t_serial_pulse();
    logic rdy; logic [31:0] v;
    wr(6'h04, 32'h0);
    send(8'h3C, rdy);
    chk("R7 ready when empty", 32'(rdy), 1);
    chk("R8 rx pulse", 32'(irq_rx_pulse), 1);
    chk("R8 rx level low", 32'(irq_rx_level), 0);
    chk("R7 ready drops", 32'(rx_ready), 0);
    @(posedge clk); #1;
    chk("R8 rx pulse one cycle", 32'(irq_rx_pulse), 0);
    rd(6'h10, v); chk("R4 status avail", v, 32'h7);
    rd(6'h18, v); chk("R4 fstat avail", v, 32'h1);
    send(8'h77, rdy);
    chk("R7 refused while held", 32'(rdy), 0);
    rd(6'h24, v); chk("R11 read byte", v, 32'h3C);
    rd(6'h10, v); chk("R11 avail cleared", v, 32'h6);
  endtask

  task automatic t_serial_level();
    logic rdy; logic [31:0] v;
    wr(6'h04, 32'h100);
    send(8'h81, rdy);
    chk("R8 rx level set", 32'(irq_rx_level), 1);
    chk("R8 no pulse in level", 32'(irq_rx_pulse), 0);
    @(posedge clk); #1;
    chk("R8 rx level sticky", 32'(irq_rx_level), 1);
    rd(6'h24, v); chk("R11 read level byte", v, 32'h81);
    chk("R11 level dropped", 32'(irq_rx_level), 0);
    send(8'h42, rdy);
    chk("R8 level again", 32'(irq_rx_level), 1);
    wr(6'h04, 32'h0);
    chk("R10 ctrl forces rx level low", 32'(irq_rx_level), 0);
    rd(6'h24, v); chk("R11 read after ctrl", v, 32'h42);
  endtask

  task automatic t_loopback();
    logic [31:0] v;
    wr(6'h04, 32'h20);
    wr(6'h20, 32'h0000_FF5A);
    chk("R6 no tx_valid", 32'(tx_valid), 0);
    chk("R6 rx pulse", 32'(irq_rx_pulse), 1);
    chk("R9 tx pulse on loop", 32'(irq_tx_pulse), 1);
    rd(6'h10, v); chk("R6 avail", v, 32'h7);
    rd(6'h24, v); chk("R6 looped byte", v, 32'h5A);
  endtask

  task automatic t_collision();
    logic [31:0] v; logic rdy;
    wr(6'h04, 32'h20);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h11;
    rx_valid = 1'b1; rx_data = 8'h22;
    #1 rdy = rx_ready;
    chk("R12 ready low on loop write", 32'(rdy), 0);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(6'h24, v); chk("R12 loop byte wins", v, 32'h11);
    @(posedge clk); #1;
    rx_valid = 1'b0;
    rd(6'h24, v); chk("R12 serial byte later", v, 32'h22);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_plain_regs();
    t_status_ignore();
    t_tx_pulse();
    t_tx_level();
    t_serial_pulse();
    t_serial_level();
    t_loopback();
    t_collision();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule